// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of equal width and returns a product twice that width. It works iteratively: each clock cycle of the loop inspects the lowest remaining bit of the multiplier. When that bit is set, the current (progressively doubled) multiplicand is added into an accumulator. A full product takes a fixed number of cycles, independent of the operand values.

The logic is split into a datapath and a finite-state controller. The datapath holds four registers: a double-width multiplicand that moves left, a multiplier that moves right, a double-width accumulator and an iteration counter. The controller sees only three inputs: the request, the multiplier's lowest bit and the counter's top bit. From these it drives eight single-bit strobes into the datapath.

A user holds the operands and pulses `start` while the block is idle. The user then waits for `done`. The product stays on `z` until the next request is accepted.

Top module: `shmul_top`

## Requirements
- R1: While reset is asserted, and after it is released, `done` is 0 and `z` is 0 until a request is accepted.
- R2: When `done` rises, `z` equals the unsigned product of the `x` and `y` captured for that request.
- R3: `done` rises exactly OPW+4 rising clock edges after the edge that accepts `start` (20 edges for OPW=16). The edge that accepts `start` counts as the first.
- R4: The edge that accepts `start` also drives `done` low.
- R5: While idle with `done` high and `start` low, `done` stays high and `z` stays unchanged.
- R6: A `start` pulse during a running multiplication is ignored. The running result, and the cycle in which it completes, are unchanged.
- R7: `x` and `y` are captured on the second edge after acceptance. Later changes to them have no effect on the result.
- R8: Each loop iteration always shifts the multiplicand left, shifts the multiplier right and increments the counter. The add into the accumulator happens only when the multiplier's lowest bit is 1.
- R9: The loop runs exactly OPW iterations. Its exit is taken from the counter's top bit, and the counter never exceeds OPW.
- R10: A new `start` given while idle with `done` high is accepted at once, with the same timing as a first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request a multiplication (sampled only when idle) |
| x | input | OPW | Multiplicand |
| y | input | OPW | Multiplier |
| z | output | 2*OPW | Product |
| done | output | 1 | Product valid, held until the next request is accepted |

## Verification
The bench builds the block with the default OPW=16. At that width the loop takes 16 iterations, so the expected latency is a fixed 20 edges that can be counted directly. The width also makes the all-ones operands reachable, and these drive the carry chain of the 32-bit accumulator over its full length. The single 16-bit width also lets the bench reach the counter's exit bit (bit 4) after exactly 16 increments, and each operand pattern is checked against a product computed in the bench.

// File: rtl/shmul_pkg.sv
package shmul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_STEP = 2'd2,
    ST_FIN  = 2'd3
  } shmul_st_e;

  // Datapath strobes driven by the controller
  typedef struct packed {
    logic ld_a;   // load multiplicand from x
    logic ld_b;   // load multiplier from y
    logic clr_m;  // clear accumulator
    logic clr_i;  // clear iteration counter
    logic inc_i;  // increment iteration counter
    logic add_m;  // accumulate multiplicand
    logic shl_a;  // multiplicand one place left
    logic shr_b;  // multiplier one place right
  } shmul_strb_t;

endpackage

// File: rtl/shmul_rstsync.sv
module shmul_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/shmul_ctrl.sv
module shmul_ctrl
  import shmul_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        b_lsb,
  input  logic        cnt_top,
  output shmul_strb_t strb,
  output shmul_st_e   state,
  output logic        done
);

  shmul_st_e st_q, st_d;
  logic      done_q, done_d, done_en;

  // next-state and strobe decode
  always_comb begin
    st_d = st_q;
    strb = '0;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_INIT;
      ST_INIT: begin
        strb.ld_a  = 1'b1;
        strb.ld_b  = 1'b1;
        strb.clr_m = 1'b1;
        strb.clr_i = 1'b1;
        st_d       = ST_STEP;
      end
      ST_STEP: begin
        if (cnt_top) begin
          st_d = ST_FIN;
        end else begin
          strb.inc_i = 1'b1;
          strb.shl_a = 1'b1;
          strb.shr_b = 1'b1;
          strb.add_m = b_lsb;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // done: cleared on acceptance, set when the loop has finished
  always_comb begin
    done_en = ((st_q == ST_IDLE) && start) || (st_q == ST_FIN);
    done_d  = (st_q == ST_FIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (done_en) done_q <= done_d;
    end
  end

  assign state = st_q;
  assign done  = done_q;

endmodule

// File: rtl/shmul_dpath.sv
module shmul_dpath
  import shmul_pkg::*;
#(
  parameter int OPW = 16,
  localparam int PW = 2 * OPW,
  localparam int CW = $clog2(OPW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  shmul_strb_t   strb,
  input  logic [OPW-1:0] x,
  input  logic [OPW-1:0] y,
  output logic [PW-1:0] z,
  output logic          b_lsb,
  output logic [CW-1:0] cnt
);

  logic [PW-1:0]  a_q, a_d, m_q, m_d;
  logic [OPW-1:0] b_q, b_d;
  logic [CW-1:0]  i_q, i_d;
  logic           a_en, b_en, m_en, i_en;

  always_comb begin
    a_en = strb.ld_a | strb.shl_a;
    a_d  = strb.ld_a ? {{OPW{1'b0}}, x} : {a_q[PW-2:0], 1'b0};

    b_en = strb.ld_b | strb.shr_b;
    b_d  = strb.ld_b ? y : {1'b0, b_q[OPW-1:1]};

    m_en = strb.clr_m | strb.add_m;
    m_d  = strb.clr_m ? '0 : (m_q + a_q);

    i_en = strb.clr_i | strb.inc_i;
    i_d  = strb.clr_i ? '0 : (i_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      m_q <= '0;
      i_q <= '0;
    end else begin
      if (a_en) a_q <= a_d;
      if (b_en) b_q <= b_d;
      if (m_en) m_q <= m_d;
      if (i_en) i_q <= i_d;
    end
  end

  assign z     = m_q;
  assign b_lsb = b_q[0];
  assign cnt   = i_q;

endmodule

// File: rtl/shmul_top.sv
module shmul_top
  import shmul_pkg::*;
#(
  parameter int OPW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OPW-1:0]   x,
  input  logic [OPW-1:0]   y,
  output logic [2*OPW-1:0] z,
  output logic             done
);

  localparam int CW = $clog2(OPW) + 1;

  logic          rst_q_n;
  shmul_strb_t   strb;
  shmul_st_e     state;
  logic          b_lsb;
  logic [CW-1:0] cnt;

  // loop exit uses only the counter's top bit, so OPW must be a power of two
  generate
    if ((1 << (CW - 1)) != OPW) begin : g_bad_width
      $error("shmul_top: OPW must be a power of two");
    end
  endgenerate

  shmul_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  shmul_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .start   (start),
    .b_lsb   (b_lsb),
    .cnt_top (cnt[CW-1]),
    .strb    (strb),
    .state   (state),
    .done    (done)
  );

  shmul_dpath #(.OPW(OPW)) u_dp (
    .clk   (clk),
    .rst_n (rst_q_n),
    .strb  (strb),
    .x     (x),
    .y     (y),
    .z     (z),
    .b_lsb (b_lsb),
    .cnt   (cnt)
  );

endmodule

// File: rtl/shmul_chk.sv
module shmul_chk
  import shmul_pkg::*;
#(
  parameter int OPW = 16,
  localparam int CW = $clog2(OPW) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic [2*OPW-1:0] z,
  input shmul_strb_t      strb,
  input shmul_st_e        state,
  input logic             b_lsb,
  input logic [CW-1:0]    cnt
);

  // cycles since acceptance, used instead of a deep $past window
  int unsigned lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             lat_q <= 0;
    else if (state == ST_IDLE && start)     lat_q <= 1;
    else if (lat_q != 0 && lat_q < 100000)  lat_q <= lat_q + 1;
  end

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> lat_q == OPW + 4);

  p_done_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done);

  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(z)));

  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> (state != ST_INIT));

  p_iter_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.inc_i |-> (strb.shl_a && strb.shr_b));

  p_add_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.shl_a |-> (strb.add_m == b_lsb));

  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(OPW));

  p_finish_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> cnt == CW'(OPW));

endmodule

bind shmul_top shmul_chk #(.OPW(OPW)) u_chk (
  .clk   (clk),
  .rst_n (rst_q_n),
  .start (start),
  .done  (done),
  .z     (z),
  .strb  (strb),
  .state (state),
  .b_lsb (b_lsb),
  .cnt   (cnt)
);

// File: tb/sim_shmul_top.sv
`timescale 1ns/1ps
module sim_shmul_top;

  localparam int OPW = 16;
  localparam int PW  = 2 * OPW;
  localparam int LAT = OPW + 4;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [OPW-1:0] x, y;
  logic [PW-1:0]  z;
  logic           done;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  shmul_top #(.OPW(OPW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x(x), .y(y), .z(z), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      finish_run();
    end
  end

  // One multiplication; optional start pulse injected while busy (R6).
  task automatic run_mul(input logic [OPW-1:0] xa, input logic [OPW-1:0] yb,
                         input bit inject, input string tag);
    logic [PW-1:0] expv;
    int edges;
    expv = PW'(xa) * PW'(yb);
    @(negedge clk);
    x = xa; y = yb; start = 1'b1;
    @(posedge clk);                // edge 1: accepted
    @(negedge clk);
    start = 1'b0;
    check({tag, " R4 done low after accept"}, PW'(done), '0);
    @(posedge clk);                // edge 2: operands captured
    @(negedge clk);
    x = ~xa; y = yb ^ 16'h5a5a;    // R7: later changes must not matter
    edges = 2;
    while (!done && edges < 100) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (inject && edges == 8) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    check({tag, " R3 latency"}, PW'(edges), PW'(LAT));
    check({tag, " R2 R7 product"}, z, expv);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; x = '0; y = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 done in reset", PW'(done), '0);
    check("R1 z in reset", z, '0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 done after release", PW'(done), '0);
    check("R1 z after release", z, '0);
  endtask

  task automatic t_corners();
    run_mul(16'h0000, 16'h0000, 1'b0, "zero*zero");
    run_mul(16'h0001, 16'hbeef, 1'b0, "one*val");
    run_mul(16'h1234, 16'h0000, 1'b0, "val*zero");
    run_mul(16'hffff, 16'hffff, 1'b0, "ones*ones");
    run_mul(16'hffff, 16'h0001, 1'b0, "ones*one");
    run_mul(16'h8000, 16'h8000, 1'b0, "msb*msb R8 R9");
  endtask

  task automatic t_random();
    for (int k = 0; k < 12; k++) begin
      logic [OPW-1:0] ra, rb;
      ra = OPW'($urandom);
      rb = OPW'($urandom);
      run_mul(ra, rb, 1'b0, "random R8");
    end
  endtask

  task automatic t_busy();
    run_mul(16'h00ab, 16'h0c0d, 1'b1, "R6 start while busy");
  endtask

  task automatic t_hold();
    logic [PW-1:0] zs;
    zs = z;
    @(negedge clk);
    x = 16'h7777; y = 16'h3333;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R5 done held", PW'(done), PW'(1));
    check("R5 z held", z, zs);
  endtask

  task automatic t_back2back();
    run_mul(16'h0101, 16'h0202, 1'b0, "R10 first");
    run_mul(16'hfffe, 16'h0003, 1'b0, "R10 immediate restart");
  endtask

  initial begin
    t_reset();
    t_corners();
    t_random();
    t_busy();
    t_hold();
    t_back2back();
    finish_run();
  end

endmodule